// File: doc/BRIEF.md
# I3C SDR Private Read Controller

This block is the controller side of a single-data-rate private read on an I3C bus. When it gets a go strobe it claims the bus with a START condition. It sends the broadcast header (address 0x7E with the read/write bit at 0) and checks that the header is acknowledged. It then issues a repeated START and sends the 7-bit target address with the read/write bit at 1. If the target acknowledges, the block clocks in data bytes. Each byte is followed by a transition bit driven by the target: a 1 means the target has more data, and a 0 means it has finished.

The block stops reading as soon as the target reports its last byte or the requested byte count has been received, whichever comes first. In the second case the target still wants to send more. The block cuts it off by pulling SDA low while SCL is high during the transition bit, which forms a repeated START. Every transfer, including one refused at an address phase, ends with a STOP condition.

Received bytes are presented one at a time with a single-cycle valid strobe. A done pulse and a sticky refusal flag report how the transfer ended. SCL is driven push-pull. SDA uses an output-enable/value pair, and the pad is expected to resolve it with a pull-up.

Top module: `i3c_sdr_reader`

## Requirements
- R1: After reset the block is idle. In this state scl_o=1 and sda_oe=0 (SDA released), and rx_valid, done and nack are all 0.
- R2: A go pulse in idle produces a START (SDA falls while SCL is high). The next eight bits on SDA, taken at SCL rising edges and MSB first, are the header 0xFC (broadcast address 0x7E followed by read/write bit 0).
- R3: If SDA is low at the ninth SCL rise after the header START, the block releases SDA, raises SCL, and pulls SDA low while SCL is high (repeated START). It then sends {tgt_addr, 1'b1} MSB first. The address is the one captured when go was accepted.
- R4: If SDA is high at the acknowledge rise of either address phase, the block sets nack and goes straight to STOP without reading any data. nack stays 1 until the next accepted go clears it.
- R5: Data bits are sampled at SCL rising edges, MSB first. Each completed byte appears on rx_data together with a single-cycle rx_valid pulse.
- R6: If the transition bit after a byte reads 0, the block issues STOP with no further repeated START.
- R7: If the transition bit reads 1 and the byte count has reached max_bytes, the block pulls SDA low while SCL is still high (repeated START) and then issues STOP. A max_bytes of 0 is treated as 1.
- R8: If the transition bit reads 1 and fewer than max_bytes bytes have been received, SDA stays released and the next byte is read.
- R9: Every transfer ends with a STOP (SDA rises while SCL is high), followed by a single-cycle done pulse and a return to idle. A go pulse while a transfer is in progress has no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| go | input | 1 | Start a read (accepted only in idle) |
| tgt_addr | input | 7 | Target address, captured on go |
| max_bytes | input | CNT_W | Maximum number of bytes to read, captured on go (0 acts as 1) |
| sda_i | input | 1 | Resolved SDA line level |
| scl_o | output | 1 | SCL drive |
| sda_oe | output | 1 | SDA drive enable (0 = released to pull-up) |
| sda_o | output | 1 | SDA drive value when enabled |
| rx_data | output | 8 | Last received data byte |
| rx_valid | output | 1 | One-cycle strobe marking a new rx_data |
| done | output | 1 | One-cycle pulse after STOP |
| nack | output | 1 | An address phase was not acknowledged |

## Verification
A wrong phase or segment in the controller shows up directly on the bus. The header or address bits come out wrong, or SDA moves while SCL is high outside START, repeated START and STOP. Either fault is visible within one SCL period. A bad byte count or a wrong transition-bit decision shows up at the end of the transfer: the number of rx_valid strobes is wrong, or the closing repeated START appears or is missing, no later than the transition bit that follows the wrong decision. A stuck refusal flag or stuck sequencer is visible on nack, or as a done pulse that is missing or doubled, within a few SCL periods after STOP.

// File: rtl/i3c_rd_pkg.sv
package i3c_rd_pkg;

  localparam logic [6:0] BCAST_ADDR = 7'h7E;

  // one phase of a bus symbol; each lasts one divider period
  typedef enum logic [3:0] {
    ST_IDLE, ST_START, ST_LO, ST_HI,
    ST_SR_LO, ST_SR_HI, ST_SR_FALL, ST_ABORT,
    ST_SP_LO, ST_SP_HI, ST_SP_REL
  } rd_state_t;

  // which field the current bit belongs to
  typedef enum logic [2:0] {
    SG_HDR, SG_HACK, SG_ADR, SG_AACK, SG_DATA, SG_TBIT
  } rd_seg_t;

  typedef struct packed {
    logic scl;
    logic oe;
    logic o;
  } pin_t;

  function automatic pin_t pins_for(rd_state_t st, rd_seg_t sg,
                                    logic [2:0] b, logic [6:0] a);
    logic [7:0] hb;
    logic [7:0] ab;
    pin_t p;
    hb = {BCAST_ADDR, 1'b0};
    ab = {a, 1'b1};
    p = '{scl: 1'b1, oe: 1'b0, o: 1'b1};
    case (st)
      ST_START, ST_SR_FALL, ST_ABORT, ST_SP_HI: p = '{scl: 1'b1, oe: 1'b1, o: 1'b0};
      ST_SP_LO:                              p = '{scl: 1'b0, oe: 1'b1, o: 1'b0};
      ST_SR_LO:                              p = '{scl: 1'b0, oe: 1'b0, o: 1'b1};
      ST_LO, ST_HI: begin
        p.scl = (st == ST_HI);
        if (sg == SG_HDR) begin
          p.oe = 1'b1;
          p.o  = hb[3'd7 - b];
        end else if (sg == SG_ADR) begin
          p.oe = 1'b1;
          p.o  = ab[3'd7 - b];
        end
      end
      default: p = '{scl: 1'b1, oe: 1'b0, o: 1'b1};
    endcase
    return p;
  endfunction

endpackage

// File: rtl/i3c_rd_tick.sv
module i3c_rd_tick #(
  parameter int HALF = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic run,
  output logic tick
);
  localparam int TW = (HALF > 1) ? $clog2(HALF) : 1;
  localparam logic [TW-1:0] LAST = TW'(HALF - 1);

  logic [TW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst || !run)     cnt_q <= '0;
    else if (cnt_q == LAST) cnt_q <= '0;
    else                 cnt_q <= cnt_q + 1'b1;
  end

  assign tick = run && (cnt_q == LAST);

endmodule

// File: rtl/i3c_rd_shift.sv
module i3c_rd_shift (
  input  logic       clk,
  input  logic       rst,
  input  logic       shift_en,
  input  logic       bit_in,
  output logic [7:0] byte_nxt
);
  logic [7:0] sh_q;

  always_ff @(posedge clk) begin
    if (rst)           sh_q <= '0;
    else if (shift_en) sh_q <= byte_nxt;
  end

  assign byte_nxt = {sh_q[6:0], bit_in};

endmodule

// File: rtl/i3c_rd_count.sv
module i3c_rd_count #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr,
  input  logic [CNT_W-1:0] limit,
  input  logic             inc,
  output logic             last
);
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] lim_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
      lim_q <= '0;
    end else if (clr) begin
      cnt_q <= '0;
      lim_q <= limit;
    end else if (inc) begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  // a zero limit is met after the first byte, so it behaves as one
  assign last = (cnt_q >= lim_q);

  // R7
  cnt_no_wrap_chk: assert property (@(posedge clk) disable iff (rst)
    inc |-> (cnt_q != '1));

endmodule

// File: rtl/i3c_sdr_reader.sv
module i3c_sdr_reader
  import i3c_rd_pkg::*;
#(
  parameter int HALF  = 4,
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             go,
  input  logic [6:0]       tgt_addr,
  input  logic [CNT_W-1:0] max_bytes,
  input  logic             sda_i,
  output logic             scl_o,
  output logic             sda_oe,
  output logic             sda_o,
  output logic [7:0]       rx_data,
  output logic             rx_valid,
  output logic             done,
  output logic             nack
);
  rd_state_t  state_q, state_n;
  rd_seg_t    seg_q, seg_n;
  logic [2:0] bit_q, bit_n;
  logic [6:0] addr_q;
  logic       ack_q, tbit_q;
  logic       tick, last, go_acc, sample, shift_en, byte_end;
  logic [7:0] byte_nxt;
  pin_t       pin_n;

  assign go_acc   = go && (state_q == ST_IDLE);
  assign sample   = tick && (state_q == ST_LO);
  assign shift_en = sample && (seg_q == SG_DATA);
  assign byte_end = shift_en && (bit_q == 3'd7);

  i3c_rd_tick #(.HALF(HALF)) u_tick (
    .clk(clk), .rst(rst), .run(state_q != ST_IDLE), .tick(tick));

  i3c_rd_shift u_shift (
    .clk(clk), .rst(rst), .shift_en(shift_en), .bit_in(sda_i), .byte_nxt(byte_nxt));

  i3c_rd_count #(.CNT_W(CNT_W)) u_count (
    .clk(clk), .rst(rst), .clr(go_acc), .limit(max_bytes),
    .inc(byte_end), .last(last));

  always_comb begin
    state_n = state_q;
    seg_n   = seg_q;
    bit_n   = bit_q;
    case (state_q)
      ST_IDLE:  if (go) state_n = ST_START;
      ST_START: if (tick) begin
        state_n = ST_LO;
        seg_n   = SG_HDR;
        bit_n   = '0;
      end
      ST_LO:    if (tick) state_n = ST_HI;
      ST_HI: if (tick) begin
        state_n = ST_LO;
        case (seg_q)
          SG_HDR, SG_ADR, SG_DATA: begin
            if (bit_q == 3'd7) begin
              bit_n = '0;
              seg_n = (seg_q == SG_HDR) ? SG_HACK :
                      (seg_q == SG_ADR) ? SG_AACK : SG_TBIT;
            end else begin
              bit_n = bit_q + 3'd1;
            end
          end
          SG_HACK: state_n = ack_q ? ST_SR_LO : ST_SP_LO;
          SG_AACK: begin
            if (ack_q) begin
              seg_n = SG_DATA;
              bit_n = '0;
            end else begin
              state_n = ST_SP_LO;
            end
          end
          default: begin
            if (!tbit_q)   state_n = ST_SP_LO;
            else if (last) state_n = ST_ABORT;
            else begin
              seg_n = SG_DATA;
              bit_n = '0;
            end
          end
        endcase
      end
      ST_SR_LO:   if (tick) state_n = ST_SR_HI;
      ST_SR_HI:   if (tick) state_n = ST_SR_FALL;
      ST_SR_FALL: if (tick) begin
        state_n = ST_LO;
        seg_n   = SG_ADR;
        bit_n   = '0;
      end
      ST_ABORT:   if (tick) state_n = ST_SP_LO;
      ST_SP_LO:   if (tick) state_n = ST_SP_HI;
      ST_SP_HI:   if (tick) state_n = ST_SP_REL;
      default:    if (tick) state_n = ST_IDLE;
    endcase
  end

  assign pin_n = pins_for(state_n, seg_n, bit_n, addr_q);

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q  <= ST_IDLE;
      seg_q    <= SG_HDR;
      bit_q    <= '0;
      addr_q   <= '0;
      ack_q    <= 1'b0;
      tbit_q   <= 1'b0;
      scl_o    <= 1'b1;
      sda_oe   <= 1'b0;
      sda_o    <= 1'b1;
      rx_data  <= '0;
      rx_valid <= 1'b0;
      done     <= 1'b0;
      nack     <= 1'b0;
    end else begin
      state_q  <= state_n;
      seg_q    <= seg_n;
      bit_q    <= bit_n;
      scl_o    <= pin_n.scl;
      sda_oe   <= pin_n.oe;
      sda_o    <= pin_n.o;
      rx_valid <= byte_end;
      done     <= tick && (state_q == ST_SP_REL);
      if (go_acc) addr_q <= tgt_addr;
      if (sample && (seg_q == SG_HACK || seg_q == SG_AACK)) ack_q <= !sda_i;
      if (sample && seg_q == SG_TBIT) tbit_q <= sda_i;
      if (byte_end) rx_data <= byte_nxt;
      if (go_acc) nack <= 1'b0;
      else if (tick && state_q == ST_HI && !ack_q &&
               (seg_q == SG_HACK || seg_q == SG_AACK)) nack <= 1'b1;
    end
  end

  logic ctl_line;
  assign ctl_line = !(sda_oe && !sda_o);

  // R2
  sda_edge_chk: assert property (@(posedge clk) disable iff (rst)
    (scl_o && $past(scl_o) && (ctl_line != $past(ctl_line)))
      |-> (state_q inside {ST_START, ST_SR_FALL, ST_ABORT, ST_SP_REL}));

  // R4
  nack_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (nack && !go) |=> nack);

  // R5
  rx_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    rx_valid |=> !rx_valid);

  // R7
  abort_cause_chk: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_ABORT) |-> (last && tbit_q));

  // R9
  done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  // R9
  go_ignored_chk: assert property (@(posedge clk) disable iff (rst)
    (state_q != ST_IDLE && go) |=> (addr_q == $past(addr_q)));

endmodule

// File: tb/i3c_sdr_reader_test.sv
module i3c_sdr_reader_test;
  localparam int CNT_W = 8;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic go = 1'b0;
  logic [6:0] tgt_addr = '0;
  logic [CNT_W-1:0] max_bytes = '0;
  logic scl_o, sda_oe, sda_o, rx_valid, done, nack;
  logic [7:0] rx_data;
  logic tgt_oe = 1'b0;
  logic tgt_o = 1'b1;
  wire  sda_bus = (sda_oe ? sda_o : 1'b1) & (tgt_oe ? tgt_o : 1'b1);

  always #2 clk = ~clk;

  i3c_sdr_reader #(.HALF(4), .CNT_W(CNT_W)) uut (
    .clk(clk), .rst(rst), .go(go), .tgt_addr(tgt_addr), .max_bytes(max_bytes),
    .sda_i(sda_bus), .scl_o(scl_o), .sda_oe(sda_oe), .sda_o(sda_o),
    .rx_data(rx_data), .rx_valid(rx_valid), .done(done), .nack(nack));

  // vector: {addr[20:14], max[13:6], hdr_ack[5], adr_ack[4], offered[3:0]}
  localparam logic [20:0] VEC [0:7] = '{
    {7'h2B, 8'd3, 1'b1, 1'b1, 4'd3},
    {7'h2B, 8'd2, 1'b1, 1'b1, 4'd5},
    {7'h11, 8'd4, 1'b1, 1'b1, 4'd1},
    {7'h55, 8'd1, 1'b1, 1'b1, 4'd4},
    {7'h7F, 8'd0, 1'b1, 1'b1, 4'd3},
    {7'h40, 8'd3, 1'b0, 1'b1, 4'd3},
    {7'h2B, 8'd3, 1'b1, 1'b0, 4'd3},
    {7'h01, 8'd6, 1'b1, 1'b1, 4'd6}
  };

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  bit finished = 0;

  // target model configuration
  int cur_v = 0;
  bit t_hack = 0, t_aack = 0;
  int t_navail = 0;

  // observations
  int frame = 0, rcnt = 0, got = 0, done_cnt = 0;
  bit sr_end = 0, stop_seen = 0;
  logic [7:0] hdr_sh = '0, adr_sh = '0;
  logic scl_r = 1'b1, sda_r = 1'b1;

  function automatic logic [7:0] pat(int v, int b);
    return 8'((v * 53 + b * 29 + 150) ^ (b << 5));
  endfunction

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  always @(negedge clk) begin
    cyc++;
    if (cyc > 150000 && !finished) begin
      finished = 1;
      errors++;
      $display("FAIL watchdog: actual %0d expected below %0d cycles", cyc, 150000);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  always @(negedge clk) begin
    int nxt, b, idx;
    logic [7:0] db;
    if (!rst) begin
      if (rx_valid) begin
        chk(rx_data == pat(cur_v, got), "R5", "rx byte", rx_data, pat(cur_v, got));
        got++;
      end
      if (done) done_cnt++;
      if (scl_r && scl_o && sda_r && !sda_bus) begin
        if (frame == 2) sr_end = 1;
        frame++;
        rcnt = 0;
        tgt_oe = 0;
      end else if (scl_r && scl_o && !sda_r && sda_bus) begin
        frame = 0;
        stop_seen = 1;
        tgt_oe = 0;
      end else if (!scl_r && scl_o) begin
        rcnt++;
        if (frame == 1 && rcnt <= 8) hdr_sh = {hdr_sh[6:0], sda_bus};
        if (frame == 2 && rcnt <= 8) adr_sh = {adr_sh[6:0], sda_bus};
        if (frame == 2 && rcnt >= 10 && ((rcnt - 10) % 9) == 8) tgt_oe = 0;
      end else if (scl_r && !scl_o) begin
        nxt = rcnt + 1;
        tgt_oe = 0;
        if (frame == 1 && nxt == 9 && t_hack) begin tgt_oe = 1; tgt_o = 0; end
        if (frame == 2 && nxt == 9 && t_aack) begin tgt_oe = 1; tgt_o = 0; end
        if (frame == 2 && nxt >= 10 && t_aack) begin
          b = (nxt - 10) / 9;
          idx = (nxt - 10) % 9;
          if (b < t_navail) begin
            db = pat(cur_v, b);
            tgt_oe = 1;
            tgt_o = (idx < 8) ? db[7 - idx] : (b + 1 < t_navail);
          end
        end
      end
      scl_r = scl_o;
      sda_r = sda_bus;
    end
  end

  task automatic run_vec(input int v, input logic [20:0] vec, input bit busy_go);
    int lim, exp_cnt, waitc;
    bit exp_nack, exp_abort;
    @(posedge clk);
    cur_v = v;
    t_hack = vec[5];
    t_aack = vec[4];
    t_navail = int'(vec[3:0]);
    got = 0; done_cnt = 0; sr_end = 0; stop_seen = 0;
    hdr_sh = '0; adr_sh = '0;
    lim = (vec[13:6] == 0) ? 1 : int'(vec[13:6]);
    exp_nack = !(vec[5] && vec[4]);
    exp_cnt = exp_nack ? 0 : ((t_navail < lim) ? t_navail : lim);
    exp_abort = !exp_nack && (t_navail > exp_cnt);
    @(negedge clk);
    tgt_addr = vec[20:14];
    max_bytes = vec[13:6];
    go = 1;
    @(negedge clk);
    go = 0;
    tgt_addr = 7'h33;
    max_bytes = 8'd9;
    if (busy_go) begin
      repeat (100) @(negedge clk);
      go = 1;
      @(negedge clk);
      go = 0;
    end
    waitc = 0;
    while (done_cnt == 0 && waitc < 20000) begin
      @(negedge clk);
      waitc++;
    end
    chk(done_cnt == 1, "R9", "done after transfer", done_cnt, 1);
    chk(stop_seen, "R9", "STOP before done", stop_seen, 1);
    chk(nack == exp_nack, "R4", "nack", nack, exp_nack);
    chk(got == exp_cnt, (exp_cnt > 1) ? "R8" : "R6", "byte count", got, exp_cnt);
    chk(sr_end == exp_abort, exp_abort ? "R7" : "R6", "closing repeated START",
        sr_end, exp_abort);
    chk(hdr_sh == 8'hFC, "R2", "header", hdr_sh, 8'hFC);
    if (vec[5])
      chk(adr_sh == {vec[20:14], 1'b1}, "R3", "address", adr_sh, {vec[20:14], 1'b1});
    repeat (20) @(negedge clk);
    chk(nack == exp_nack, "R4", "nack held", nack, exp_nack);
    chk(done_cnt == 1, "R9", "single done pulse", done_cnt, 1);
    chk(scl_o && sda_bus, "R9", "bus idle", {scl_o, sda_bus}, 3);
  endtask

  initial begin
    repeat (5) @(negedge clk);
    // R1 reset state
    chk(scl_o == 1 && sda_oe == 0, "R1", "pins in reset", {scl_o, sda_oe}, 2);
    chk(!rx_valid && !done && !nack, "R1", "flags in reset",
        {rx_valid, done, nack}, 0);
    rst = 0;
    repeat (3) @(negedge clk);
    chk(scl_o == 1 && sda_oe == 0, "R1", "idle pins", {scl_o, sda_oe}, 2);
    for (int i = 0; i < 8; i++) run_vec(i, VEC[i], 1'b0);
    // R9 go while busy: address and count stay those of the first go
    run_vec(0, VEC[0], 1'b1);
    // R4 nack cleared by the next go
    run_vec(5, VEC[5], 1'b0);
    run_vec(3, VEC[3], 1'b0);
    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule